// File: doc/BRIEF.md
# Dual-Rail Enable Sequencer

This controller powers up two regulator channels from their own enable inputs. When either enable goes high, it waits until the supply monitor reports a good supply. It then steps through a shared bring-up sequence of four stages, in this fixed order: latching trim values, starting the bandgap, starting the voltage and current references, and fast-charging the reference filter capacitor. Each stage is a request/acknowledge exchange with the analog side. Once the last stage is acknowledged, the controller drives a ramp-enable output for each enabled channel.

Channel 1 has priority. Channel 2 starts ramping only when one of these holds: channel 1 is not enabled, or channel 1 reports its output at target. The exception is a channel 2 that was already ramping before channel 1 was enabled; it keeps running, and channel 1 starts at once. A supply drop disables both ramps together and sends the controller back to lockout. The full bring-up sequence then reruns when the supply recovers. A stage that is not acknowledged within a programmable number of cycles also sends the controller back to lockout.

Top module: `dual_rail_sequencer`

## Requirements
- R1: While in shutdown (`shutdown`=1, entered from reset or when both enables are low), `rampEn` is 0 and `stageReq` is 0.
- R2: With an enable high and `supplyOk` low, the controller leaves shutdown (`shutdown`=0) but raises no `stageReq`.
- R3: Stages are requested in the order `stageId`=0 (trim latch), 1 (bandgap), 2 (references), 3 (filter capacitor charge). The controller advances one stage on each cycle in which `stageDone` is high, and `stageId` holds while the acknowledge is absent.
- R4: The cycle after stage 3 is acknowledged, `rampEn[0]` equals `chEn[0]`.
- R5: While `chEn[0]` is high and channel 2 is not yet ramping, `rampEn[1]` stays 0 until `atTarget[0]` is seen high. It rises one cycle after that.
- R6: When channel 2 is ramping and `chEn[0]` then rises, `rampEn[0]` rises one cycle later and `rampEn[1]` stays high, whatever `atTarget[0]` is.
- R7: When `chEn[1]` rises first and `chEn[0]` rises before `rampEn[1]` does, channel 1 ramps first and channel 2 waits for `atTarget[0]`.
- R8: A cycle with `supplyOk` low clears both ramp enables and `stageReq` on the next cycle. When the supply returns, bring-up restarts at `stageId`=0.
- R9: Lowering one enable clears only that channel's ramp enable one cycle later. No stage is requested again, and raising it again resumes that channel's ramp one cycle later.
- R10: A stage whose request stays unacknowledged for `STAGE_TIMEOUT` cycles drops `stageReq` for one cycle (lockout). It then restarts at `stageId`=0 if the supply and an enable are still present.
- R11: Both enables low for a cycle puts the block into shutdown on the next cycle, with both ramp enables cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chEn | input | 2 | Channel enables, bit 0 = channel 1 |
| supplyOk | input | 1 | Supply above lockout threshold (hysteresis applied upstream) |
| stageDone | input | 1 | Acknowledge for the current bring-up stage |
| atTarget | input | 2 | Channel output has reached its target, bit 0 = channel 1 |
| stageReq | output | 1 | A bring-up stage is being requested |
| stageId | output | 2 | Index of the requested stage |
| rampEn | output | 2 | Per-channel ramp enable, bit 0 = channel 1 |
| shutdown | output | 1 | Block is in full shutdown |

## Verification
Directed sequences cover the enable orderings that decide priority:
- both enables together, where channel 2 must wait for channel 1's target flag;
- channel 2 alone and then channel 1 after channel 2 is already ramping, where channel 1 starts at once;
- channel 2 first and channel 1 during bring-up, where channel 1 still goes first.

Supply loss in the running state, a single-channel disable and re-enable, and a stage left unacknowledged separate restarting bring-up from keeping the shared stages up. A long random run then toggles enables, supply, acknowledges and target flags. It catches wrong priority decisions or wrong restart points in orderings the directed cases do not reach.

// File: rtl/railseq_pkg.sv
package railseq_pkg;
  localparam int CH_COUNT    = 2;
  localparam int STAGE_COUNT = 4;
  localparam int STAGE_ID_W  = $clog2(STAGE_COUNT);

  // Bring-up order is behaviour: index 0 runs first.
  typedef enum logic [STAGE_ID_W-1:0] {
    STG_TRIM    = 2'd0,
    STG_BANDGAP = 2'd1,
    STG_REFS    = 2'd2,
    STG_FILTER  = 2'd3
  } stage_t;

  typedef enum logic [1:0] {
    SEQ_OFF   = 2'd0,
    SEQ_LOCK  = 2'd1,
    SEQ_STAGE = 2'd2,
    SEQ_RUN   = 2'd3
  } seqMode_t;

  typedef struct packed {
    logic tmrClr;   // restart stage wait timer
    logic tmrInc;   // another cycle spent waiting in the same stage
    logic runNext;  // controller will be in the running state next cycle
  } seqStrobe_t;
endpackage

// File: rtl/railseq_ctrl.sv
module railseq_ctrl
  import railseq_pkg::*;
#(
  parameter int STAGE_TIMEOUT = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CH_COUNT-1:0]   chEn,
  input  logic                  supplyOk,
  input  logic                  stageDone,
  input  logic                  tmrExpired,
  output seqStrobe_t            strobe,
  output logic                  stageReq,
  output logic [STAGE_ID_W-1:0] stageId,
  output logic                  shutdown
);
  localparam logic [STAGE_ID_W-1:0] LAST_STAGE = STAGE_ID_W'(STG_FILTER);

  seqMode_t              mode, modeNext;
  logic [STAGE_ID_W-1:0] idx, idxNext;
  logic                  anyEn;

  assign anyEn = |chEn;

  always_comb begin
    modeNext = mode;
    idxNext  = idx;
    unique case (mode)
      SEQ_OFF: begin
        if (anyEn) modeNext = SEQ_LOCK;
      end
      SEQ_LOCK: begin
        if (!anyEn) begin
          modeNext = SEQ_OFF;
        end else if (supplyOk) begin
          modeNext = SEQ_STAGE;
          idxNext  = STAGE_ID_W'(STG_TRIM);
        end
      end
      SEQ_STAGE: begin
        if (!anyEn) begin
          modeNext = SEQ_OFF;
        end else if (!supplyOk) begin
          modeNext = SEQ_LOCK;
        end else if (stageDone) begin
          if (idx == LAST_STAGE) modeNext = SEQ_RUN;
          else                   idxNext  = idx + 1'b1;
        end else if (tmrExpired) begin
          modeNext = SEQ_LOCK;
        end
      end
      SEQ_RUN: begin
        if (!anyEn)         modeNext = SEQ_OFF;
        else if (!supplyOk) modeNext = SEQ_LOCK;
      end
      default: modeNext = SEQ_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode <= SEQ_OFF;
      idx  <= '0;
    end else begin
      mode <= modeNext;
      idx  <= idxNext;
    end
  end

  always_comb begin
    strobe.tmrInc  = (mode == SEQ_STAGE) && (modeNext == SEQ_STAGE) && (idxNext == idx);
    strobe.tmrClr  = !strobe.tmrInc;
    strobe.runNext = (modeNext == SEQ_RUN);
  end

  assign stageReq = (mode == SEQ_STAGE);
  assign stageId  = idx;
  assign shutdown = (mode == SEQ_OFF);
endmodule

// File: rtl/railseq_dp.sv
module railseq_dp
  import railseq_pkg::*;
#(
  parameter int STAGE_TIMEOUT = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic [CH_COUNT-1:0] chEn,
  input  logic [CH_COUNT-1:0] atTarget,
  output logic                tmrExpired,
  output logic [CH_COUNT-1:0] rampEn
);
  localparam int TMR_W = (STAGE_TIMEOUT > 2) ? $clog2(STAGE_TIMEOUT) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(STAGE_TIMEOUT - 1);

  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              tmr <= '0;
    else if (strobe.tmrClr) tmr <= '0;
    else if (strobe.tmrInc) tmr <= tmr + 1'b1;
  end

  assign tmrExpired = (tmr == TMR_LAST);

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
    logic rampNext;
    if (c == 0) begin : g_lead
      assign rampNext = strobe.runNext && chEn[c];
    end else begin : g_follow
      // Follower ramps when already ramping, the leader is off, or the leader settled.
      assign rampNext = strobe.runNext && chEn[c] &&
                        (rampEn[c] || !chEn[0] || atTarget[0]);
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rampEn[c] <= 1'b0;
      else       rampEn[c] <= rampNext;
    end
  end
endmodule

// File: rtl/dual_rail_sequencer.sv
module dual_rail_sequencer
  import railseq_pkg::*;
#(
  parameter int STAGE_TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] chEn,
  input  logic       supplyOk,
  input  logic       stageDone,
  input  logic [1:0] atTarget,
  output logic       stageReq,
  output logic [1:0] stageId,
  output logic [1:0] rampEn,
  output logic       shutdown
);
  seqStrobe_t strobe;
  logic       tmrExpired;

  railseq_ctrl #(.STAGE_TIMEOUT(STAGE_TIMEOUT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .chEn       (chEn),
    .supplyOk   (supplyOk),
    .stageDone  (stageDone),
    .tmrExpired (tmrExpired),
    .strobe     (strobe),
    .stageReq   (stageReq),
    .stageId    (stageId),
    .shutdown   (shutdown)
  );

  railseq_dp #(.STAGE_TIMEOUT(STAGE_TIMEOUT)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .chEn       (chEn),
    .atTarget   (atTarget),
    .tmrExpired (tmrExpired),
    .rampEn     (rampEn)
  );
endmodule

// File: rtl/dual_rail_sequencer_chk.sv
module dual_rail_sequencer_chk #(
  parameter int STAGE_TIMEOUT = 64
) (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] chEn,
  input logic       supplyOk,
  input logic       stageDone,
  input logic [1:0] atTarget,
  input logic       stageReq,
  input logic [1:0] stageId,
  input logic [1:0] rampEn,
  input logic       shutdown
);
  int unsigned waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      waitCnt <= 0;
    else if (stageReq && !stageDone) waitCnt <= waitCnt + 1;
    else                            waitCnt <= 0;
  end

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    shutdown |-> (rampEn == 2'b00 && !stageReq));

  assert_stage_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stageReq && !stageDone) |=> (!stageReq || $stable(stageId)));

  assert_follow_waits_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rampEn[1]) |-> (!$past(chEn[0]) || $past(atTarget[0])));

  assert_supply_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (rampEn == 2'b00 && !stageReq));

  assert_lead_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    rampEn[0] |-> $past(chEn[0]));

  assert_stage_timeout_R10: assert property (@(posedge clk) disable iff (!rstN)
    stageReq |-> (waitCnt < STAGE_TIMEOUT));

  assert_both_off_R11: assert property (@(posedge clk) disable iff (!rstN)
    (chEn == 2'b00) |=> (shutdown && rampEn == 2'b00));
endmodule

bind dual_rail_sequencer dual_rail_sequencer_chk #(.STAGE_TIMEOUT(STAGE_TIMEOUT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .chEn      (chEn),
  .supplyOk  (supplyOk),
  .stageDone (stageDone),
  .atTarget  (atTarget),
  .stageReq  (stageReq),
  .stageId   (stageId),
  .rampEn    (rampEn),
  .shutdown  (shutdown)
);

// File: tb/tb_dual_rail_sequencer.sv
`timescale 1ns/1ps
module tb_dual_rail_sequencer;
  localparam int TMO = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] chEn = 2'b00;
  logic       supplyOk = 1'b0;
  logic       stageDone = 1'b0;
  logic [1:0] atTarget = 2'b00;
  logic       stageReq;
  logic [1:0] stageId;
  logic [1:0] rampEn;
  logic       shutdown;

  int checks = 0;
  int failures = 0;
  int wdCycles = 0;
  bit finished = 0;

  // bench reference: 0 off, 1 lockout, 2 stage, 3 running
  int mMode = 0;
  int mIdx = 0;
  int mTmr = 0;
  bit [1:0] mRamp = 2'b00;

  always #2.5 clk = ~clk;

  dual_rail_sequencer #(.STAGE_TIMEOUT(TMO)) dut (
    .clk(clk), .rstN(rstN), .chEn(chEn), .supplyOk(supplyOk),
    .stageDone(stageDone), .atTarget(atTarget), .stageReq(stageReq),
    .stageId(stageId), .rampEn(rampEn), .shutdown(shutdown)
  );

  task automatic checkEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit [1:0] nextRamp(int newMode, bit [1:0] en, bit [1:0] tgt, bit [1:0] old);
    bit [1:0] r;
    r[0] = (newMode == 3) && en[0];
    r[1] = (newMode == 3) && en[1] && (old[1] || !en[0] || tgt[0]);
    return r;
  endfunction

  task automatic modelStep();
    int nm = mMode;
    int ni = mIdx;
    int nt = 0;
    bit any = |chEn;
    case (mMode)
      0: if (any) nm = 1;
      1: if (!any) nm = 0; else if (supplyOk) begin nm = 2; ni = 0; end
      2: begin
        if (!any) nm = 0;
        else if (!supplyOk) nm = 1;
        else if (stageDone) begin
          if (mIdx == 3) nm = 3; else ni = mIdx + 1;
        end else if (mTmr == TMO - 1) nm = 1;
        else nt = mTmr + 1;
      end
      default: if (!any) nm = 0; else if (!supplyOk) nm = 1;
    endcase
    mRamp = nextRamp(nm, chEn, atTarget, mRamp);
    mMode = nm;
    mIdx = ni;
    mTmr = nt;
  endtask

  task automatic modelCompare();
    checkEq("R1/R11", "shutdown", int'(shutdown), int'(mMode == 0));
    checkEq("R3", "stageReq", int'(stageReq), int'(mMode == 2));
    if (mMode == 2) checkEq("R3", "stageId", int'(stageId), mIdx);
    checkEq("R4", "rampEn0", int'(rampEn[0]), int'(mRamp[0]));
    checkEq("R5", "rampEn1", int'(rampEn[1]), int'(mRamp[1]));
  endtask

  task automatic cycle();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    modelCompare();
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wdCycles++;
    if (wdCycles > 60000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", wdCycles);
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checkEq("R1", "reset shutdown", int'(shutdown), 1);
    checkEq("R1", "reset rampEn", int'(rampEn), 0);
    checkEq("R1", "reset stageReq", int'(stageReq), 0);
    cycle();

    // R2: enables without supply
    chEn = 2'b11;
    repeat (4) cycle();
    checkEq("R2", "stageReq no supply", int'(stageReq), 0);
    checkEq("R2", "shutdown no supply", int'(shutdown), 0);

    // R3/R4/R5: ordered bring-up, both enabled together
    supplyOk = 1'b1;
    cycle();
    checkEq("R3", "first stage", int'(stageId), 0);
    checkEq("R3", "first req", int'(stageReq), 1);
    stageDone = 1'b1;
    for (int s = 1; s < 4; s++) begin
      cycle();
      checkEq("R3", "stage order", int'(stageId), s);
    end
    cycle();
    stageDone = 1'b0;
    checkEq("R4", "lead ramps first", int'(rampEn), 1);
    repeat (3) cycle();
    checkEq("R5", "follow waits", int'(rampEn), 1);
    atTarget = 2'b01;
    cycle();
    checkEq("R5", "follow after target", int'(rampEn), 3);

    // R9: single-channel disable
    chEn = 2'b10;
    cycle();
    checkEq("R9", "only lead cleared", int'(rampEn), 2);
    checkEq("R9", "no restart", int'(stageReq), 0);
    chEn = 2'b11;
    cycle();
    checkEq("R9", "lead resumes", int'(rampEn), 3);

    // R8: supply loss and rerun
    supplyOk = 1'b0;
    cycle();
    checkEq("R8", "ramps cleared", int'(rampEn), 0);
    checkEq("R8", "no request", int'(stageReq), 0);
    supplyOk = 1'b1;
    cycle();
    checkEq("R8", "restart stage", int'(stageId), 0);
    checkEq("R8", "restart req", int'(stageReq), 1);
    stageDone = 1'b1;
    repeat (4) cycle();
    stageDone = 1'b0;

    // R11: both off
    chEn = 2'b00;
    cycle();
    checkEq("R11", "shutdown", int'(shutdown), 1);
    checkEq("R11", "ramps", int'(rampEn), 0);

    // R6: follower alone, then lead joins
    atTarget = 2'b00;
    chEn = 2'b10;
    cycle(); cycle();
    stageDone = 1'b1;
    repeat (4) cycle();
    stageDone = 1'b0;
    checkEq("R6", "follower alone", int'(rampEn), 2);
    chEn = 2'b11;
    cycle();
    checkEq("R6", "lead joins at once", int'(rampEn), 3);
    chEn = 2'b00;
    cycle();

    // R7: follower enabled first, lead joins during bring-up
    chEn = 2'b10;
    cycle(); cycle(); cycle();
    chEn = 2'b11;
    stageDone = 1'b1;
    repeat (4) cycle();
    stageDone = 1'b0;
    checkEq("R7", "lead first", int'(rampEn), 1);
    cycle();
    checkEq("R7", "follow still waits", int'(rampEn), 1);
    atTarget = 2'b01;
    cycle();
    checkEq("R7", "follow after target", int'(rampEn), 3);
    chEn = 2'b00;
    atTarget = 2'b00;
    cycle();

    // R10: unacknowledged stage
    chEn = 2'b01;
    cycle(); cycle();
    begin
      int held = 0;
      while (stageReq && held < 100) begin
        held++;
        cycle();
      end
      checkEq("R10", "cycles held", held, TMO);
    end
    checkEq("R10", "lockout gap", int'(stageReq), 0);
    cycle();
    checkEq("R10", "restart req", int'(stageReq), 1);
    checkEq("R10", "restart stage", int'(stageId), 0);
    chEn = 2'b00;
    cycle();

    // random mix checked against the reference each cycle
    for (int n = 0; n < 5000; n++) begin
      if ($urandom % 16 == 0) chEn = 2'($urandom);
      supplyOk  = ($urandom % 40) != 0;
      stageDone = ($urandom % 3) == 0;
      if ($urandom % 8 == 0) atTarget = 2'($urandom);
      cycle();
    end

    finishRun();
  end
endmodule